// File: doc/BRIEF.md
# LPC Host Cycle Engine

This block is the host side of a 4-bit multiplexed low-pin-count bus. A local requester presents one I/O or memory access (direction, address, write byte) with a valid/ready handshake. The engine then runs the whole bus cycle. It drives the active-low frame strobe and the nibble lines through start, cycle type, address, optional write data and the host-to-peripheral turnaround. It then listens for sync nibbles, collects read data and lets the final turnaround pass. At the end it raises a one-clock done pulse with an error bit.

While the engine waits for the peripheral to become ready, it counts consecutive wait-state sync nibbles. Short waits and long waits each have their own limit, both set by parameters. A peripheral that stalls past its limit, or that answers with an undefined sync code, does not hang the bus. The engine ends the cycle with the bus abort sequence and reports an error.

Top module: `lpc_host_engine`

## Requirements
- R1: After reset and whenever no cycle is in progress, `lframe_n` is 1, `lad_oe` is 0, `req_ready` is 1 and `done` is 0.
- R2: An accepted request puts out one clock with `lframe_n` at 0 and `lad_out` at 0000. The next clock has `lframe_n` at 1 and carries the cycle-type nibble: bit 2 is 1 for memory, bit 1 is 1 for write, and bits 3 and 0 are 0.
- R3: The address follows the cycle-type nibble, most significant nibble first. It takes four nibbles (`req_addr[15:0]`) for I/O and eight nibbles (`req_addr[31:0]`) for memory.
- R4: A write sends the data byte as two nibbles, low nibble first, right after the address. Every cycle then has a two-clock turnaround: the host drives 1111 on the first clock and sets `lad_oe` to 0 on the second.
- R5: Sync 0000 completes the cycle. A read then samples two data nibbles, low first, into `rdata`. Two final turnaround clocks follow with `lad_oe` at 0. `done` is then high for exactly one clock with `err` at 0.
- R6: Sync 1010 completes the cycle in the same way as 0000, but `err` is 1 with `done`.
- R7: Sync 0101 (short wait) is tolerated for up to `SHORT_LIMIT` consecutive clocks. The next consecutive 0101 starts an abort.
- R8: Sync 0110 (long wait) is tolerated for up to `LONG_LIMIT` consecutive clocks. The next consecutive 0110 starts an abort.
- R9: Any sync nibble other than 0000, 0101, 0110 and 1010 starts an abort on the clock after it is sampled.
- R10: An abort holds `lframe_n` at 0 for four clocks with `lad_oe` at 1 and `lad_out` at 1111. One clock with `lframe_n` at 1 follows, and then `done` with `err` at 1.
- R11: `req_ready` is 1 only while idle. A request is taken on a clock where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Cycle address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Error status, valid with `done` |
| rdata | output | 8 | Read byte, valid with `done` on a good read |
| lframe_n | output | 1 | Frame strobe, active low |
| lad_out | output | 4 | Nibble driven onto the bus |
| lad_oe | output | 1 | Host drives the nibble bus |
| lad_in | input | 4 | Nibble sampled from the bus |

## Verification
The bench sweeps every wait-run length from zero to one past each limit, for short and long waits alike. An off-by-one in the timeout would either abort on the last legal wait or let one illegal wait through. Either way the frame strobe would fall a clock early or late. Each undefined sync code is tried so that a decoder that treats one as a wait or as ready fails, because it would then hang or return data instead of aborting. I/O and memory, read and write, are crossed with several addresses. This catches nibble-order mistakes, a wrong address length and a turnaround the host keeps driving.

// File: rtl/lpc_host_engine.sv
module lpc_host_engine #(
  parameter int SHORT_LIMIT = 8,
  parameter int LONG_LIMIT  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_mem,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        done,
  output logic        err,
  output logic [7:0]  rdata,
  output logic        lframe_n,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  input  logic [3:0]  lad_in
);
  localparam int CW = $clog2(LONG_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CTYP, S_ADDR, S_WDAT, S_TAR1, S_TAR2,
    S_SYNC, S_RDAT, S_FTR1, S_FTR2, S_ABRT, S_RCOV
  } st_t;

  st_t         st;
  logic [2:0]  cnt;
  logic [CW-1:0] wcnt;
  logic        mem_q, wr_q, err_q;
  logic [31:0] addr_q;
  logic [7:0]  wdata_q;

  wire sync_ok  = lad_in == 4'h0;
  wire sync_bad = lad_in == 4'hA;
  wire sync_sw  = lad_in == 4'h5;
  wire sync_lw  = lad_in == 4'h6;
  wire sync_rsv = !(sync_ok || sync_bad || sync_sw || sync_lw);
  wire wait_over = (sync_sw && wcnt >= CW'(SHORT_LIMIT)) ||
                   (sync_lw && wcnt >= CW'(LONG_LIMIT));
  wire [2:0] addr_last = mem_q ? 3'd7 : 3'd3;
  wire [2:0] nib_idx   = addr_last - cnt;

  assign req_ready = st == S_IDLE;
  assign lframe_n  = !(st == S_START || st == S_ABRT);
  assign lad_oe    = st inside {S_START, S_CTYP, S_ADDR, S_WDAT, S_TAR1, S_ABRT};

  always_comb begin
    case (st)
      S_CTYP:         lad_out = {1'b0, mem_q, wr_q, 1'b0};
      S_ADDR:         lad_out = addr_q[{nib_idx, 2'b00} +: 4];
      S_WDAT:         lad_out = wdata_q[{cnt[0], 2'b00} +: 4];
      S_TAR1, S_ABRT: lad_out = 4'hF;
      default:        lad_out = 4'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; wcnt <= '0;
      mem_q <= 1'b0; wr_q <= 1'b0; err_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0;
      done <= 1'b0; err <= 1'b0; rdata <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_q <= req_mem; wr_q <= req_write;
          addr_q <= req_addr; wdata_q <= req_wdata;
          err_q <= 1'b0; st <= S_START;
        end
        S_START: st <= S_CTYP;
        S_CTYP: begin cnt <= '0; st <= S_ADDR; end
        S_ADDR: if (cnt == addr_last) begin
          cnt <= '0; st <= wr_q ? S_WDAT : S_TAR1;
        end else cnt <= cnt + 3'd1;
        S_WDAT: if (cnt[0]) begin
          cnt <= '0; st <= S_TAR1;
        end else cnt <= cnt + 3'd1;
        S_TAR1: st <= S_TAR2;
        S_TAR2: begin wcnt <= '0; st <= S_SYNC; end
        S_SYNC: if (sync_ok || sync_bad) begin
          err_q <= sync_bad; cnt <= '0;
          st <= wr_q ? S_FTR1 : S_RDAT;
        end else if (sync_rsv || wait_over) begin
          err_q <= 1'b1; cnt <= '0; st <= S_ABRT;
        end else wcnt <= wcnt + 1'b1;
        S_RDAT: begin
          rdata[{cnt[0], 2'b00} +: 4] <= lad_in;
          if (cnt[0]) begin cnt <= '0; st <= S_FTR1; end
          else cnt <= cnt + 3'd1;
        end
        S_FTR1: st <= S_FTR2;
        S_FTR2: begin done <= 1'b1; err <= err_q; st <= S_IDLE; end
        S_ABRT: if (cnt == 3'd3) st <= S_RCOV; else cnt <= cnt + 3'd1;
        S_RCOV: begin done <= 1'b1; err <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_accept_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !lframe_n && lad_out == 4'h0 && lad_oe);
  assert_frame_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lframe_n) && lad_out == 4'h0 |=> lframe_n);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_short_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SYNC && sync_sw && wcnt == CW'(SHORT_LIMIT) |=> !lframe_n && lad_out == 4'hF);
  assert_reserved_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SYNC && sync_rsv |=> !lframe_n && lad_oe);
  assert_abort_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lframe_n) && $past(lad_out) == 4'hF |-> !$past(lframe_n, 4) && !$past(lframe_n, 1));
endmodule

// File: tb/lpc_host_engine_bench.sv
module lpc_host_engine_bench;
  localparam int SL = 3;
  localparam int LL = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_mem = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [3:0] lad_in = '0;
  logic req_ready, done, err, lframe_n, lad_oe;
  logic [7:0] rdata;
  logic [3:0] lad_out;

  int compared = 0, mismatched = 0;

  lpc_host_engine #(.SHORT_LIMIT(SL), .LONG_LIMIT(LL)) u_lpc_host_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mem(req_mem), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .err(err), .rdata(rdata),
    .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe), .lad_in(lad_in));

  always #5 clk = ~clk;

  logic       ef [0:127];
  logic       eo [0:127];
  logic [3:0] el [0:127];
  logic [3:0] di [0:127];
  string      er [0:127];
  int n;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic push(input logic f, input logic o, input logic [3:0] l,
                      input logic [3:0] d, input string r);
    ef[n] = f; eo[n] = o; el[n] = l; di[n] = d; er[n] = r; n++;
  endtask

  task automatic run(input bit mem, input bit wr, input logic [31:0] addr,
                     input logic [7:0] wd, input logic [7:0] rd, input int nwait,
                     input logic [3:0] wcode, input logic [3:0] fcode);
    int na, lim;
    bit abort, xerr;
    string wr_tag;
    n = 0; abort = 0; xerr = 0;
    push(0, 1, 4'h0, 0, "R2");
    push(1, 1, {1'b0, mem, wr, 1'b0}, 0, "R2");
    na = mem ? 8 : 4;
    for (int i = 0; i < na; i++) push(1, 1, addr[4*(na-1-i) +: 4], 0, "R3");
    if (wr) begin
      push(1, 1, wd[3:0], 0, "R4");
      push(1, 1, wd[7:4], 0, "R4");
    end
    push(1, 1, 4'hF, 0, "R4");
    push(1, 0, 4'h0, 0, "R4");
    lim = (wcode == 4'h5) ? SL : LL;
    wr_tag = (wcode == 4'h5) ? "R7" : "R8";
    for (int i = 0; i < nwait; i++) begin
      push(1, 0, 0, wcode, wr_tag);
      if (i >= lim) begin abort = 1; break; end
    end
    if (!abort) begin
      push(1, 0, 0, fcode, "R9");
      if (!(fcode == 4'h0 || fcode == 4'hA)) abort = 1;
      else begin
        xerr = (fcode == 4'hA);
        if (!wr) begin
          push(1, 0, 0, rd[3:0], "R5");
          push(1, 0, 0, rd[7:4], "R5");
        end
        push(1, 0, 0, 0, "R5");
        push(1, 0, 0, 0, "R5");
      end
    end
    if (abort) begin
      xerr = 1;
      for (int i = 0; i < 4; i++) push(0, 1, 4'hF, 0, "R10");
      push(1, 0, 0, 0, "R10");
    end

    @(negedge clk);
    req_valid = 1; req_mem = mem; req_write = wr; req_addr = addr; req_wdata = wd;
    chk(req_ready === 1'b1, "R11", "ready before accept", req_ready, 1);
    @(posedge clk);
    for (int c = 0; c <= n; c++) begin
      @(negedge clk);
      req_valid = 0;
      lad_in = (c < n) ? di[c] : 4'h0;
      if (c < n) begin
        chk(lframe_n === ef[c], er[c], "lframe_n", lframe_n, ef[c]);
        chk(lad_oe === eo[c], er[c], "lad_oe", lad_oe, eo[c]);
        if (eo[c]) chk(lad_out === el[c], er[c], "lad_out", lad_out, el[c]);
        chk(done === 1'b0, "R5", "early done", done, 0);
        chk(req_ready === 1'b0, "R11", "ready while busy", req_ready, 0);
      end else begin
        chk(done === 1'b1, "R5", "done pulse", done, 1);
        chk(err === xerr, xerr ? (abort ? "R10" : "R6") : "R5", "err", err, xerr);
        if (!wr && !abort) chk(rdata === rd, "R5", "rdata", rdata, rd);
        chk(req_ready === 1'b1 && lframe_n === 1'b1 && lad_oe === 1'b0, "R1",
            "idle after cycle", {req_ready, lframe_n, lad_oe}, 3'b110);
      end
    end
    @(negedge clk);
    chk(done === 1'b0, "R5", "done one clock", done, 0);
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lframe_n === 1'b1 && lad_oe === 1'b0 && req_ready === 1'b1 && done === 1'b0,
        "R1", "reset state", {lframe_n, lad_oe, req_ready, done}, 4'b1010);
    rst_n = 1;
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 3; k++) begin
          logic [31:0] a;
          logic [7:0] wd, rd;
          a  = 32'h9E3779B9 * (k + 1) + 32'(m * 2 + w);
          wd = 8'(k * 37 + 11);
          rd = 8'(k * 53 + 200);
          run(m[0], w[0], a, wd, rd, 0, 4'h5, 4'h0);
          run(m[0], w[0], a, wd, rd, 0, 4'h5, 4'hA);
          if (k == 0) begin
            for (int nw = 1; nw <= SL + 1; nw++) run(m[0], w[0], a, wd, rd, nw, 4'h5, 4'h0);
            for (int nw = 1; nw <= LL + 1; nw++) run(m[0], w[0], a, wd, rd, nw, 4'h6, 4'hA);
            for (int f = 0; f < 16; f++)
              if (!(f == 0 || f == 5 || f == 6 || f == 10))
                run(m[0], w[0], a, wd, rd, 1, 4'h5, 4'(f));
          end
        end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule